// File: doc/BRIEF.md
# Banked Scratchpad with Hardware Stack

This block is the 128-byte on-chip scratchpad of an 8-bit microcontroller core. Three kinds of access reach one shared byte array. A direct port reads and writes any byte by its full address. A register port reaches the eight working registers of the bank that the core's status word selects, using only a 3-bit register number. A stack port pushes and pops bytes under the control of an 8-bit stack pointer, which the core can also load and observe.

The stack pointer always holds the address of the most recent byte on the stack. A push first advances the pointer and then stores at the new address. A pop returns the byte under the pointer and then moves the pointer back. The pointer resets to 07H, so the first push lands just above bank 0. Every read result is registered, and a read sees any write made in the same cycle. Accesses that fall outside the array are refused and flagged on a one-cycle error pulse.

Top module: `scp_stack_top`

## Requirements
- R1: After reset, sp_o is 07H, all read-data outputs are 00H, both error outputs are low, and every byte of the array reads 00H.
- R2: With dir_en_i high and dir_addr_i in 00H..7FH, a write stores dir_wdata_i at that byte. dir_rdata_o shows the byte one cycle after the request and holds its value while dir_en_i is low.
- R3: A read on any port returns the value written to the same byte in the same cycle by any port (write-first).
- R4: Register number n with bank_sel_i = b (2-bit, 0..3) addresses byte b*8+n. The value appears on reg_rdata_o one cycle later, and a write with reg_we_i stores reg_wdata_i there.
- R5: A push with sp_we_i low increments sp_o by one and stores push_data_i at the incremented address. sp_o shows the new value one cycle later.
- R6: A pop alone puts the byte at the current pointer on pop_data_o one cycle later and decrements the pointer. pop_data_o otherwise holds its value.
- R7: A push whose incremented pointer exceeds 7FH writes nothing, still moves the pointer (modulo 256), and pulses stk_err_o for one cycle. A pop with the pointer above 7FH returns 00H, decrements the pointer and pulses stk_err_o. stk_err_o is low after any cycle with no stack fault.
- R8: A direct access with dir_addr_i above 7FH writes nothing, returns 00H on dir_rdata_o and pulses dir_err_o one cycle later. No byte of the array is altered.
- R9: A push and a pop in the same cycle performs only the push, leaves pop_data_o unchanged and pulses stk_err_o.
- R10: sp_we_i loads sp_wdata_i into the pointer, visible one cycle later. A push or pop in the same cycle is suppressed and pulses stk_err_o.
- R11: Simultaneous writes to one byte resolve with the stack push first, the register port second and the direct port last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | 2 | Working-register bank from the status word |
| dir_en_i | input | 1 | Direct access request |
| dir_we_i | input | 1 | Direct access is a write |
| dir_addr_i | input | 8 | Direct byte address |
| dir_wdata_i | input | 8 | Direct write data |
| dir_rdata_o | output | 8 | Registered direct read data |
| dir_err_o | output | 1 | Direct address out of range, one-cycle pulse |
| reg_en_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Register access is a write |
| reg_num_i | input | 3 | Register number in the active bank |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered register read data |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | 8 | Byte to push |
| pop_data_o | output | 8 | Byte popped |
| sp_we_i | input | 1 | Load the stack pointer |
| sp_wdata_i | input | 8 | New stack-pointer value |
| sp_o | output | 8 | Current stack pointer |
| stk_err_o | output | 1 | Stack fault, one-cycle pulse |

## Verification
A wrong pointer shows on sp_o one cycle after the stack operation that caused it. It also shows later as popped bytes that do not match what was pushed, or as pushes that overwrite register banks. A wrong bank mapping or a lost write surfaces on the next read of that byte from any port, which can come many cycles later. For that reason the bench keeps a full shadow of the array and compares every read output on every cycle. A missing write-first bypass or a broken write priority shows only in the cycle where ports collide, so those collisions are forced directly as well as arising at random.

// File: rtl/scp_pkg.sv
package scp_pkg;

   // read behaviour when a byte is read and written in one cycle
   typedef enum logic {
      RD_WRITE_FIRST = 1'b0,
      RD_READ_FIRST  = 1'b1
   } rd_mode_e;

   // write-port slots, lower slot wins on a same-byte collision
   localparam int unsigned WP_PUSH = 0;
   localparam int unsigned WP_REG  = 1;
   localparam int unsigned WP_DIR  = 2;
   localparam int unsigned NUM_WP  = 3;

   // read-port slots
   localparam int unsigned RP_DIR  = 0;
   localparam int unsigned RP_REG  = 1;
   localparam int unsigned RP_POP  = 2;
   localparam int unsigned NUM_RP  = 3;

endpackage

// File: rtl/scp_ram.sv
module scp_ram
   import scp_pkg::*;
#(
   parameter int unsigned DEPTH   = 128,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_WR    = 3,
   parameter int unsigned N_RD    = 3,
   parameter rd_mode_e    RD_MODE = RD_WRITE_FIRST,
   localparam int unsigned AW     = $clog2(DEPTH)
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [N_WR-1:0]               wr_en_i,
   input  logic [N_WR-1:0][AW-1:0]       wr_addr_i,
   input  logic [N_WR-1:0][DATA_W-1:0]   wr_data_i,
   input  logic [N_RD-1:0]               rd_en_i,
   input  logic [N_RD-1:0]               rd_zero_i,
   input  logic [N_RD-1:0][AW-1:0]       rd_addr_i,
   output logic [N_RD-1:0][DATA_W-1:0]   rd_data_o
);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("scp_ram: DEPTH must be a power of two");
      end
      if (N_WR < 1 || N_RD < 1) begin : g_bad_ports
         $error("scp_ram: at least one write and one read port required");
      end
   endgenerate

   logic [DEPTH-1:0][DATA_W-1:0] mem_q;
   logic [DEPTH-1:0][DATA_W-1:0] mem_d;
   logic [DEPTH-1:0][DATA_W-1:0] rd_src;

   // highest slot applied first so slot 0 lands last and wins
   always_comb begin
      mem_d = mem_q;
      for (int p = int'(N_WR) - 1; p >= 0; p--) begin
         if (wr_en_i[p]) begin
            mem_d[wr_addr_i[p]] = wr_data_i[p];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mem_q <= '0;
      end else begin
         mem_q <= mem_d;
      end
   end

   generate
      if (RD_MODE == RD_WRITE_FIRST) begin : g_wr_first
         assign rd_src = mem_d;
      end else begin : g_rd_first
         assign rd_src = mem_q;
      end
   endgenerate

   generate
      for (genvar g = 0; g < int'(N_RD); g++) begin : g_rd
         logic [DATA_W-1:0] rd_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               rd_q <= '0;
            end else if (rd_en_i[g]) begin
               rd_q <= rd_zero_i[g] ? '0 : rd_src[rd_addr_i[g]];
            end
         end

         assign rd_data_o[g] = rd_q;

         AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !rd_en_i[g] |=> $stable(rd_data_o[g]));  // R2
      end
   endgenerate

endmodule

// File: rtl/scp_bank_map.sv
module scp_bank_map #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned REGS      = 8,
   parameter int unsigned AW        = 7,
   localparam int unsigned BSW      = $clog2(NUM_BANKS),
   localparam int unsigned RNW      = $clog2(REGS)
) (
   input  logic [BSW-1:0] bank_i,
   input  logic [RNW-1:0] num_i,
   output logic [AW-1:0]  addr_o
);

   generate
      if (NUM_BANKS < 2 || (1 << BSW) != NUM_BANKS) begin : g_bad_banks
         $error("scp_bank_map: NUM_BANKS must be a power of two, at least 2");
      end
      if (REGS < 2) begin : g_bad_regs
         $error("scp_bank_map: REGS must be at least 2");
      end
      if (BSW + RNW > AW) begin : g_bad_aw
         $error("scp_bank_map: banks do not fit the address width");
      end

      if ((1 << RNW) == REGS) begin : g_concat
         // power-of-two bank size: bank index sits directly above the register number
         assign addr_o = AW'({bank_i, num_i});
      end else begin : g_mult
         assign addr_o = AW'(int'(bank_i) * int'(REGS) + int'(num_i));
      end
   endgenerate

endmodule

// File: rtl/scp_stack_ctrl.sv
module scp_stack_ctrl #(
   parameter int unsigned DEPTH    = 128,
   parameter int unsigned SP_W     = 8,
   parameter int unsigned SP_RESET = 7,
   localparam int unsigned AW      = $clog2(DEPTH)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            push_i,
   input  logic            pop_i,
   input  logic            sp_we_i,
   input  logic [SP_W-1:0] sp_wdata_i,
   output logic [SP_W-1:0] sp_o,
   output logic            push_we_o,
   output logic [AW-1:0]   push_addr_o,
   output logic            pop_re_o,
   output logic            pop_zero_o,
   output logic [AW-1:0]   pop_addr_o,
   output logic            err_o
);

   generate
      if (AW >= SP_W) begin : g_bad_spw
         $error("scp_stack_ctrl: pointer must be wider than the array address");
      end
   endgenerate

   logic [SP_W-1:0] sp_q, sp_d, sp_inc, sp_dec;
   logic            inc_in_range, cur_in_range;
   logic            err_d, err_q;

   assign sp_inc       = sp_q + SP_W'(1);
   assign sp_dec       = sp_q - SP_W'(1);
   assign inc_in_range = ~|sp_inc[SP_W-1:AW];
   assign cur_in_range = ~|sp_q[SP_W-1:AW];

   always_comb begin
      sp_d       = sp_q;
      push_we_o  = 1'b0;
      pop_re_o   = 1'b0;
      pop_zero_o = 1'b0;
      err_d      = 1'b0;
      if (sp_we_i) begin
         // pointer load wins, any stack strobe is dropped
         sp_d  = sp_wdata_i;
         err_d = push_i | pop_i;
      end else if (push_i) begin
         // push beats a simultaneous pop
         sp_d      = sp_inc;
         push_we_o = inc_in_range;
         err_d     = ~inc_in_range | pop_i;
      end else if (pop_i) begin
         sp_d       = sp_dec;
         pop_re_o   = 1'b1;
         pop_zero_o = ~cur_in_range;
         err_d      = ~cur_in_range;
      end
   end

   assign push_addr_o = sp_inc[AW-1:0];
   assign pop_addr_o  = sp_q[AW-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sp_q  <= SP_W'(SP_RESET);
         err_q <= 1'b0;
      end else begin
         sp_q  <= sp_d;
         err_q <= err_d;
      end
   end

   assign sp_o  = sp_q;
   assign err_o = err_q;

   AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && !sp_we_i |=> sp_o == $past(sp_o) + SP_W'(1));  // R5

   AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i && !push_i && !sp_we_i |=> sp_o == $past(sp_o) - SP_W'(1));  // R6

   AST_SP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sp_we_i |=> sp_o == $past(sp_wdata_i));  // R10

   AST_LOAD_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sp_we_i && (push_i || pop_i) |=> err_o);  // R10

endmodule

// File: rtl/scp_stack_top.sv
module scp_stack_top
   import scp_pkg::*;
#(
   parameter int unsigned DEPTH         = 128,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned SP_W          = 8,
   parameter int unsigned NUM_BANKS     = 4,
   parameter int unsigned REGS_PER_BANK = 8,
   parameter int unsigned SP_RESET      = 7,
   parameter rd_mode_e    RD_MODE       = RD_WRITE_FIRST,
   localparam int unsigned AW           = $clog2(DEPTH),
   localparam int unsigned BSW          = $clog2(NUM_BANKS),
   localparam int unsigned RNW          = $clog2(REGS_PER_BANK)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [BSW-1:0]    bank_sel_i,
   input  logic              dir_en_i,
   input  logic              dir_we_i,
   input  logic [SP_W-1:0]   dir_addr_i,
   input  logic [DATA_W-1:0] dir_wdata_i,
   output logic [DATA_W-1:0] dir_rdata_o,
   output logic              dir_err_o,
   input  logic              reg_en_i,
   input  logic              reg_we_i,
   input  logic [RNW-1:0]    reg_num_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] push_data_i,
   output logic [DATA_W-1:0] pop_data_o,
   input  logic              sp_we_i,
   input  logic [SP_W-1:0]   sp_wdata_i,
   output logic [SP_W-1:0]   sp_o,
   output logic              stk_err_o
);

   generate
      if (NUM_BANKS * REGS_PER_BANK > DEPTH) begin : g_bad_fit
         $error("scp_stack_top: register banks exceed the array");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("scp_stack_top: DATA_W must be positive");
      end
      if (SP_RESET >= (1 << SP_W)) begin : g_bad_rst
         $error("scp_stack_top: SP_RESET does not fit the pointer");
      end
   endgenerate

   // direct port range check
   logic dir_in_range;
   assign dir_in_range = ~|dir_addr_i[SP_W-1:AW];

   // register number to physical byte
   logic [AW-1:0] reg_addr;

   scp_bank_map #(
      .NUM_BANKS (NUM_BANKS),
      .REGS      (REGS_PER_BANK),
      .AW        (AW)
   ) u_bank_map (
      .bank_i (bank_sel_i),
      .num_i  (reg_num_i),
      .addr_o (reg_addr)
   );

   // stack pointer control
   logic          push_we, pop_re, pop_zero;
   logic [AW-1:0] push_addr, pop_addr;

   scp_stack_ctrl #(
      .DEPTH    (DEPTH),
      .SP_W     (SP_W),
      .SP_RESET (SP_RESET)
   ) u_stack_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push_i),
      .pop_i       (pop_i),
      .sp_we_i     (sp_we_i),
      .sp_wdata_i  (sp_wdata_i),
      .sp_o        (sp_o),
      .push_we_o   (push_we),
      .push_addr_o (push_addr),
      .pop_re_o    (pop_re),
      .pop_zero_o  (pop_zero),
      .pop_addr_o  (pop_addr),
      .err_o       (stk_err_o)
   );

   // port slots into the shared array
   logic [NUM_WP-1:0]              wr_en;
   logic [NUM_WP-1:0][AW-1:0]      wr_addr;
   logic [NUM_WP-1:0][DATA_W-1:0]  wr_data;
   logic [NUM_RP-1:0]              rd_en, rd_zero;
   logic [NUM_RP-1:0][AW-1:0]      rd_addr;
   logic [NUM_RP-1:0][DATA_W-1:0]  rd_data;

   always_comb begin
      wr_en            = '0;
      wr_addr          = '0;
      wr_data          = '0;
      wr_en[WP_PUSH]   = push_we;
      wr_addr[WP_PUSH] = push_addr;
      wr_data[WP_PUSH] = push_data_i;
      wr_en[WP_REG]    = reg_en_i & reg_we_i;
      wr_addr[WP_REG]  = reg_addr;
      wr_data[WP_REG]  = reg_wdata_i;
      wr_en[WP_DIR]    = dir_en_i & dir_we_i & dir_in_range;
      wr_addr[WP_DIR]  = dir_addr_i[AW-1:0];
      wr_data[WP_DIR]  = dir_wdata_i;

      rd_en            = '0;
      rd_zero          = '0;
      rd_addr          = '0;
      rd_en[RP_DIR]    = dir_en_i;
      rd_zero[RP_DIR]  = ~dir_in_range;
      rd_addr[RP_DIR]  = dir_addr_i[AW-1:0];
      rd_en[RP_REG]    = reg_en_i;
      rd_addr[RP_REG]  = reg_addr;
      rd_en[RP_POP]    = pop_re;
      rd_zero[RP_POP]  = pop_zero;
      rd_addr[RP_POP]  = pop_addr;
   end

   scp_ram #(
      .DEPTH   (DEPTH),
      .DATA_W  (DATA_W),
      .N_WR    (NUM_WP),
      .N_RD    (NUM_RP),
      .RD_MODE (RD_MODE)
   ) u_ram (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_en_i   (rd_en),
      .rd_zero_i (rd_zero),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data)
   );

   assign dir_rdata_o = rd_data[RP_DIR];
   assign reg_rdata_o = rd_data[RP_REG];
   assign pop_data_o  = rd_data[RP_POP];

   // direct-port fault pulse
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dir_err_o <= 1'b0;
      end else begin
         dir_err_o <= dir_en_i & ~dir_in_range;
      end
   end

   AST_DIR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_en_i && (dir_addr_i > SP_W'(DEPTH - 1)) |=> dir_err_o && dir_rdata_o == '0);  // R8

   AST_DIR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dir_en_i |=> !dir_err_o);  // R8

   AST_PUSH_POP_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && pop_i |=> stk_err_o);  // R9

   AST_CLASH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && pop_i && !sp_we_i |=> $stable(pop_data_o));  // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && !sp_we_i && sp_o == SP_W'(DEPTH - 1) |=> stk_err_o);  // R7

   AST_STK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !push_i && !pop_i && !sp_we_i |=> !stk_err_o);  // R7

endmodule

// File: tb/scp_stack_top_tb.sv
`timescale 1ns/1ps
module scp_stack_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] t_bank = '0;
   logic       t_den = 0, t_dwe = 0;
   logic [7:0] t_daddr = '0, t_dwd = '0;
   logic       t_ren = 0, t_rwe = 0;
   logic [2:0] t_rnum = '0;
   logic [7:0] t_rwd = '0;
   logic       t_push = 0, t_pop = 0, t_spwe = 0;
   logic [7:0] t_pd = '0, t_spwd = '0;

   logic [7:0] o_drd, o_rrd, o_pop, o_sp;
   logic       o_derr, o_serr;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   // shadow model
   logic [7:0] m_mem [128];
   logic [7:0] e_drd, e_rrd, e_pop, e_sp;
   logic       e_derr, e_serr;

   always #10 clk = ~clk;  // 50 MHz

   scp_stack_top dut_i (
      .clk_i (clk), .rst_ni (rst_n), .bank_sel_i (t_bank),
      .dir_en_i (t_den), .dir_we_i (t_dwe), .dir_addr_i (t_daddr),
      .dir_wdata_i (t_dwd), .dir_rdata_o (o_drd), .dir_err_o (o_derr),
      .reg_en_i (t_ren), .reg_we_i (t_rwe), .reg_num_i (t_rnum),
      .reg_wdata_i (t_rwd), .reg_rdata_o (o_rrd),
      .push_i (t_push), .pop_i (t_pop), .push_data_i (t_pd),
      .pop_data_o (o_pop), .sp_we_i (t_spwe), .sp_wdata_i (t_spwd),
      .sp_o (o_sp), .stk_err_o (o_serr)
   );

   task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s %s: got %02h expected %02h at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic clear_in();
      t_den = 0; t_dwe = 0; t_ren = 0; t_rwe = 0;
      t_push = 0; t_pop = 0; t_spwe = 0;
   endtask

   // expected next outputs from the requirements
   task automatic model_step();
      logic [7:0] inc;
      int         ridx;
      inc    = e_sp + 8'd1;
      ridx   = int'(t_bank) * 8 + int'(t_rnum);
      e_derr = 0;
      e_serr = 0;
      // writes in rising priority: direct, register, push (R11)
      if (t_den && t_dwe && t_daddr < 8'h80) m_mem[t_daddr[6:0]] = t_dwd;
      if (t_ren && t_rwe) m_mem[ridx] = t_rwd;
      if (!t_spwe && t_push && inc < 8'h80) m_mem[inc[6:0]] = t_pd;
      // reads see this cycle's writes (R3)
      if (t_den) begin
         if (t_daddr < 8'h80) e_drd = m_mem[t_daddr[6:0]];
         else begin e_drd = 8'h00; e_derr = 1; end
      end
      if (t_ren) e_rrd = m_mem[ridx];
      if (t_spwe) begin
         e_serr = t_push | t_pop;
         e_sp   = t_spwd;
      end else if (t_push) begin
         e_serr = (inc >= 8'h80) | t_pop;
         e_sp   = inc;
      end else if (t_pop) begin
         e_pop  = (e_sp < 8'h80) ? m_mem[e_sp[6:0]] : 8'h00;
         e_serr = (e_sp >= 8'h80);
         e_sp   = e_sp - 8'd1;
      end
   endtask

   // apply inputs for one edge, compare at the next falling edge
   task automatic tick(input string tag);
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(tag == "" ? "R2" : tag, "dir_rdata", o_drd, e_drd);
      chk(tag == "" ? "R8" : tag, "dir_err",   {7'd0, o_derr}, {7'd0, e_derr});
      chk(tag == "" ? "R4" : tag, "reg_rdata", o_rrd, e_rrd);
      chk(tag == "" ? "R6" : tag, "pop_data",  o_pop, e_pop);
      chk(tag == "" ? "R5" : tag, "sp",        o_sp,  e_sp);
      chk(tag == "" ? "R7" : tag, "stk_err",   {7'd0, o_serr}, {7'd0, e_serr});
      clear_in();
   endtask

   task automatic dir_rd(input logic [7:0] a, input string tag);
      t_den = 1; t_daddr = a; tick(tag);
   endtask

   initial begin : main
      int unsigned r;
      for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
      e_drd = 0; e_rrd = 0; e_pop = 0; e_sp = 8'h07; e_derr = 0; e_serr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "sp", o_sp, 8'h07);
      chk("R1", "dir_rdata", o_drd, 8'h00);
      chk("R1", "reg_rdata", o_rrd, 8'h00);
      chk("R1", "pop_data", o_pop, 8'h00);
      chk("R1", "errors", {6'd0, o_derr, o_serr}, 8'h00);
      dir_rd(8'h7F, "R1");

      // R5 pushes from reset land at 08H upward
      t_push = 1; t_pd = 8'h11; tick("R5");
      t_push = 1; t_pd = 8'h22; tick("R5");
      t_push = 1; t_pd = 8'h33; tick("R5");
      dir_rd(8'h08, "R5");
      // R4 bank 1 register 0 is byte 08H, register 2 is 0AH
      t_ren = 1; t_bank = 2'd1; t_rnum = 3'd0; tick("R4");
      t_ren = 1; t_bank = 2'd1; t_rnum = 3'd2; tick("R4");
      // R4 write through bank 2 register 5, read directly at 15H
      t_ren = 1; t_rwe = 1; t_bank = 2'd2; t_rnum = 3'd5; t_rwd = 8'h5A; tick("R4");
      dir_rd(8'h15, "R4");
      // R6 pop order
      t_pop = 1; tick("R6");
      t_pop = 1; tick("R6");
      // R2 direct write then read, then hold
      t_den = 1; t_dwe = 1; t_daddr = 8'h40; t_dwd = 8'hC3; tick("R2");
      dir_rd(8'h40, "R2");
      tick("R2");
      // R3 read and write of the same byte in one cycle
      t_den = 1; t_dwe = 1; t_daddr = 8'h41; t_dwd = 8'h9E;
      t_ren = 1; t_bank = 2'd0; t_rnum = 3'd3; tick("R3");
      // R8 out-of-range write must not alias onto 05H
      t_den = 1; t_dwe = 1; t_daddr = 8'h85; t_dwd = 8'hEE; tick("R8");
      dir_rd(8'h05, "R8");
      dir_rd(8'hFF, "R8");
      // R10 pointer load clashing with a push
      t_spwe = 1; t_spwd = 8'h7E; t_push = 1; t_pd = 8'h77; tick("R10");
      dir_rd(8'h7F, "R10");
      // R7 top of array then overflow
      t_push = 1; t_pd = 8'h6D; tick("R7");
      t_push = 1; t_pd = 8'h99; tick("R7");
      tick("R7");
      t_pop = 1; tick("R7");
      t_pop = 1; tick("R7");
      // R7 wrap from FFH to 00H
      t_spwe = 1; t_spwd = 8'hFF; tick("R10");
      t_push = 1; t_pd = 8'h3C; tick("R7");
      dir_rd(8'h00, "R7");
      // R9 push and pop together
      t_push = 1; t_pop = 1; t_pd = 8'h4B; tick("R9");
      dir_rd(8'h01, "R9");
      // R11 three writers on byte 0AH
      t_spwe = 1; t_spwd = 8'h09; tick("R10");
      t_den = 1; t_dwe = 1; t_daddr = 8'h0A; t_dwd = 8'hAA;
      t_ren = 1; t_rwe = 1; t_bank = 2'd1; t_rnum = 3'd2; t_rwd = 8'hBB;
      t_push = 1; t_pd = 8'hCC; tick("R11");
      t_den = 1; t_dwe = 1; t_daddr = 8'h0B; t_dwd = 8'hAA;
      t_ren = 1; t_rwe = 1; t_bank = 2'd1; t_rnum = 3'd3; t_rwd = 8'hBB; tick("R11");

      // constrained random traffic
      r = $urandom(32'h5CA1AB1E);
      for (int c = 0; c < 4000; c++) begin
         r = $urandom % 100;
         t_den   = (r < 50);
         t_dwe   = $urandom % 2 == 1;
         t_daddr = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 128);
         t_dwd   = 8'($urandom);
         t_ren   = ($urandom % 100) < 40;
         t_rwe   = $urandom % 2 == 1;
         t_bank  = 2'($urandom);
         t_rnum  = 3'($urandom);
         t_rwd   = 8'($urandom);
         t_push  = ($urandom % 100) < 20;
         t_pop   = ($urandom % 100) < 20;
         t_pd    = 8'($urandom);
         t_spwe  = ($urandom % 100) < 3;
         t_spwd  = 8'($urandom % 140);
         tick("");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule